// File: doc/BRIEF.md
# Phase-Shedding Power State Sequencer

This block decides whether one phase of a daisy-chained multiphase regulator stays active or is shed. An active-low power-state request from the system passes through a two-flop synchronizer. While that synchronized request is held, the block counts rising edges of the daisy-chain phase-input pulse. Once the configured number of pulses has been seen, a shed flag is set on the next falling edge of the clock.

While the shed flag is set, the block does three things. It disables the gate drivers, which puts them in tri-state. It disconnects the phase from the shared current-report bus. It bypasses the phase's daisy-chain flip-flop, so the phase pulse passes straight to the next phase. The remaining phases then space themselves over the shorter ring.

When the request is withdrawn, the flag clears on a falling edge and the pulse count starts again from zero. When the flag is clear, the daisy-chain flip-flop delays the phase input by one clock.

Top module: `phase_shed_seq`

## Requirements
- R1: After reset, drv_en_o is 1, iout_conn_o is 1 and phase_out_o is 0.
- R2: While pwr_state_ni is held high (1 means no request), the block never sheds, however many phase pulses arrive.
- R3: A held low request sheds only after SHED_PULSES (default 8) rising edges of phase_in_i have been sampled. After one pulse fewer, drv_en_o is still 1.
- R4: The shed flag sets on the first falling clock edge after the rising edge that samples the final counted pulse, and not before that falling edge.
- R5: While shed, drv_en_o is 0, meaning the drivers are in tri-state. Otherwise it is 1.
- R6: While shed, iout_conn_o is 0, meaning the phase is disconnected from the current bus. Otherwise it is 1.
- R7: While shed, phase_out_o equals phase_in_i with no clock delay.
- R8: While not shed, phase_out_o equals phase_in_i as sampled at the previous rising clock edge.
- R9: When pwr_state_ni returns high, the shed flag clears on the falling edge that follows the second rising edge after the change. A new request then needs a full SHED_PULSES count again.
- R10: A request withdrawn before the count completes leaves the flag at 0 and discards the partial count.
- R11: The request reaches the counter through two flip-flops. A pulse sampled by the first rising edge after the request falls is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_state_ni | input | 1 | Power-state request; low asks this phase to shed |
| phase_in_i | input | 1 | Daisy-chain phase pulse from the previous phase |
| phase_out_o | output | 1 | Daisy-chain phase pulse to the next phase |
| drv_en_o | output | 1 | Gate driver enable; 0 puts the drivers in tri-state |
| iout_conn_o | output | 1 | Current-report connect; 0 disconnects from the shared bus |

## Verification
A pulse counter that is off by one moves the moment drv_en_o falls by one whole pulse period. The bench therefore checks the outputs just before and just after the falling edge that should set the flag. A count left over from an earlier aborted or released request makes a later shed arrive early, so after each release and each abort the bench repeats the short-by-one test. A fault in the flag or the bypass mux shows at phase_out_o in the same cycle: during shed it checks that phase_out_o follows phase_in_i with no clock edge in between, and outside shed it checks the one-clock delay.

// File: rtl/phase_shed_pkg.sv
package phase_shed_pkg;
  typedef struct packed {
    logic drv_en;
    logic iout_conn;
    logic bypass;
  } shed_ctrl_t;

  function automatic shed_ctrl_t ctrl_from_flag(input logic shed);
    shed_ctrl_t c;
    c.drv_en    = ~shed;
    c.iout_conn = ~shed;
    c.bypass    = shed;
    return c;
  endfunction
endpackage

// File: rtl/shed_req_sync.sv
module shed_req_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_async_i,
  output logic req_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], req_async_i};
  end

  assign req_o = sync_q[STAGES-1];

  // R11: request takes two edges to show
  assert_sync_latency_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(req_async_i, 2));
endmodule

// File: rtl/shed_pulse_counter.sv
module shed_pulse_counter #(
  parameter int unsigned PULSES = 8,
  localparam int unsigned CNT_W = $clog2(PULSES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic phase_in_i,
  output logic done_o
);
  logic             phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  assign rise   = phase_in_i & ~phase_q;
  assign done_o = (cnt_q == CNT_W'(PULSES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_in_i;
      if (!req_i)              cnt_q <= '0;
      else if (rise && !done_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(PULSES));
  // R10: withdrawn request discards count
  assert_cnt_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (cnt_q == '0));
endmodule

// File: rtl/shed_flag_reg.sv
module shed_flag_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic done_i,
  output logic shed_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shed_o <= 1'b0;
    else         shed_o <= req_i & done_i;
  end

  assert_shed_set_R4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (req_i && done_i) |=> shed_o);
  assert_shed_clear_R9: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !req_i |=> !shed_o);
endmodule

// File: rtl/daisy_chain_stage.sv
module daisy_chain_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bypass_i,
  input  logic phase_in_i,
  output logic phase_out_o
);
  logic dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= 1'b0;
    else         dly_q <= phase_in_i;
  end

  assign phase_out_o = bypass_i ? phase_in_i : dly_q;

  assert_delay_path_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !bypass_i) |-> (phase_out_o == $past(phase_in_i)));
endmodule

// File: rtl/phase_shed_seq.sv
module phase_shed_seq
  import phase_shed_pkg::*;
#(
  parameter int unsigned SHED_PULSES = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_state_ni,
  input  logic phase_in_i,
  output logic phase_out_o,
  output logic drv_en_o,
  output logic iout_conn_o
);
  logic       req_sync;
  logic       cnt_done;
  logic       shed_flag;
  shed_ctrl_t ctrl;

  shed_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_async_i (~pwr_state_ni),
    .req_o       (req_sync)
  );

  shed_pulse_counter #(.PULSES(SHED_PULSES)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_sync),
    .phase_in_i (phase_in_i),
    .done_o     (cnt_done)
  );

  shed_flag_reg u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_sync),
    .done_i (cnt_done),
    .shed_o (shed_flag)
  );

  assign ctrl = ctrl_from_flag(shed_flag);

  daisy_chain_stage u_chain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bypass_i    (ctrl.bypass),
    .phase_in_i  (phase_in_i),
    .phase_out_o (phase_out_o)
  );

  assign drv_en_o    = ctrl.drv_en;
  assign iout_conn_o = ctrl.iout_conn;

  // R5/R6: shedding only follows a synchronized request
  assert_no_shed_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_sync && $past(!req_sync) && $past(rst_ni)) |-> (drv_en_o && iout_conn_o));
endmodule

// File: tb/phase_shed_seq_bench.sv
`timescale 1ns/1ps
module phase_shed_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_n = 1'b1;
  logic pin = 1'b0;
  logic pout, drv_en, iout_conn;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  phase_shed_seq u_phase_shed_seq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pwr_state_ni (pwr_n),
    .phase_in_i   (pin),
    .phase_out_o  (pout),
    .drv_en_o     (drv_en),
    .iout_conn_o  (iout_conn)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse();
    @(posedge clk); #1 pin = 1'b1;
    @(posedge clk); #1 pin = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) pulse();
  endtask

  task automatic request();
    @(posedge clk); #1 pwr_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic release_req();
    @(posedge clk); #1 pwr_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 drv_en", drv_en, 1'b1);
    chk("R1 iout_conn", iout_conn, 1'b1);
    chk("R1 phase_out", pout, 1'b0);
  endtask

  task automatic t_no_request();
    pulses(12);
    repeat (2) @(negedge clk);
    #1 chk("R2 drv_en idle", drv_en, 1'b1);
    chk("R2 iout idle", iout_conn, 1'b1);
  endtask

  task automatic t_delay_path();
    @(posedge clk); #1 pin = 1'b1;
    #1 chk("R8 no pass before edge", pout, 1'b0);
    @(posedge clk); #1 chk("R8 delayed high", pout, 1'b1);
    pin = 1'b0;
    #1 chk("R8 held until edge", pout, 1'b1);
    @(posedge clk); #1 chk("R8 delayed low", pout, 1'b0);
  endtask

  task automatic t_shed();
    request();
    pulses(7);
    repeat (3) @(negedge clk);
    #1 chk("R3 seven pulses no shed", drv_en, 1'b1);
    pulse();
    chk("R4 not before falling edge", drv_en, 1'b1);
    @(negedge clk); #1 chk("R4 shed at falling edge", drv_en, 1'b0);
    chk("R5 drivers tri-state", drv_en, 1'b0);
    chk("R6 current bus open", iout_conn, 1'b0);
    pin = 1'b1;
    #0.5 chk("R7 bypass high", pout, 1'b1);
    pin = 1'b0;
    #0.5 chk("R7 bypass low", pout, 1'b0);
  endtask

  task automatic t_release();
    @(posedge clk); #1 pwr_n = 1'b1;
    @(posedge clk); @(negedge clk); #1 chk("R9 still shed after one edge", drv_en, 1'b0);
    @(posedge clk); @(negedge clk); #1 chk("R9 cleared", drv_en, 1'b1);
    chk("R9 iout reconnected", iout_conn, 1'b1);
    repeat (2) @(posedge clk);
    request();
    pulses(7);
    repeat (2) @(negedge clk);
    #1 chk("R9 full recount needed", drv_en, 1'b1);
    pulse();
    @(negedge clk); #1 chk("R9 reshed after full count", drv_en, 1'b0);
    release_req();
    @(negedge clk); #1 chk("R9 clear again", drv_en, 1'b1);
  endtask

  task automatic t_abort();
    request();
    pulses(5);
    release_req();
    @(negedge clk); #1 chk("R10 aborted no shed", drv_en, 1'b1);
    request();
    pulses(7);
    repeat (2) @(negedge clk);
    #1 chk("R10 partial count discarded", drv_en, 1'b0 ^ 1'b1);
    pulse();
    @(negedge clk); #1 chk("R10 shed after fresh count", drv_en, 1'b0);
    release_req();
    @(negedge clk); #1;
  endtask

  task automatic t_sync();
    @(posedge clk); #1 pwr_n = 1'b0;
    pulses(8);
    repeat (2) @(negedge clk);
    #1 chk("R11 first pulse not counted", drv_en, 1'b1);
    pulse();
    @(negedge clk); #1 chk("R11 shed on ninth", drv_en, 1'b0);
    release_req();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    t_no_request();
    t_delay_path();
    t_shed();
    t_release();
    t_abort();
    t_sync();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule